// File: doc/BRIEF.md
# Gated-Clock Serial DAC Output Formatter

This block turns parallel stereo samples into the serial streams a pair of DAC inputs expect. It produces five signals from one free-running system clock: a bit clock, a word clock, one data line per channel and a deglitch strobe. The output runs at 2, 4 or 8 times the input sample rate. A word of 16, 18, 20 or 24 bits is shifted out MSB first right after each word-clock start edge. The bit clock then stops high for the rest of the output period, so that the DAC converts while no edges are moving.

Samples come in as 24-bit two's complement left/right pairs through a ready/valid handshake. The ready pulse lasts one clock per output period. If no sample is offered, the previous one is sent again, so the clocks never stop. The output can be coded as two's complement or complementary offset binary. The deglitch strobe has its low-going and high-going edges placed at any of 32 equal slots of the output period.

All timing comes from a phase counter. The system clock gives `CLK_PER_FS` ticks per input sample (default 512). The output period is therefore 64, 128 or 256 ticks, and a bit cell is two ticks. A small state machine sequences the bit cells. Its states are `SEQ_LOW` (first half of a bit cell, data updated, bit clock low) and `SEQ_HIGH` (second half, bit clock high). Its third state is `SEQ_HOLD` (quiet time, bit clock parked high). The transitions are: `SEQ_LOW`→`SEQ_HIGH` always. `SEQ_HIGH`→`SEQ_LOW` when more bits remain. On the last bit, `SEQ_HIGH`→`SEQ_HOLD`, or →`SEQ_LOW` if the period ends there. `SEQ_HOLD`→`SEQ_LOW` at the end of the period. Reset enters `SEQ_LOW` at phase 0.

Top module: `dac_stream_fmt`

## Requirements
- R1: The output period in system clocks is set by `osr_sel`: 00 gives 64, 01 gives 128, 10 gives 256, and 11 behaves like 00. `smp_ready` is high for exactly one clock per period, the clock before the word-start edge appears.
- R2: The word length is set by `len_sel`: 00 gives 16, 01 gives 18, 10 gives 20 and 11 gives 24 bits. The bit clock has exactly that many rising edges per period. When `osr_sel` is 10, the length is 24 whatever `len_sel` holds.
- R3: Bits leave MSB first in two-clock cells. The bit clock is low in the first clock of a cell and high in the second. The data lines change only in a clock where the bit clock falls. The first cell starts in the same clock as the word-start edge.
- R4: After the last bit, the bit clock stays high until the next word start. It falls together with the word-start edge.
- R5: With `wck_start_rise`=0, the word clock falls at word start and rises at half period. With `wck_start_rise`=1 it does the opposite.
- R6: With `offset_bin`=1, every transmitted bit except the MSB is the inverse of the two's complement bit.
- R7: Slots are period/32 clocks long and are counted from 0 at word start. `dg_o` goes low at the start of slot `dg_low_slot` and high at the start of slot `dg_high_slot`. When both name the same slot, high wins.
- R8: `smp_valid` is sampled only while `smp_ready` is high. When it is low there, the previous pair is sent again; after reset that pair is zero.
- R9: During reset the bit clock is high, `dg_o` is high, the data lines are low and `smp_ready` is high. The word clock sits at the inverse of `wck_start_rise`.
- R10: Every configuration input is sampled at word start only. A change during a period takes effect at the next word start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_FS ticks per input sample |
| rst_n | input | 1 | Active-low synchronous reset |
| osr_sel | input | 2 | Oversampling ratio select |
| len_sel | input | 2 | Output word length select |
| offset_bin | input | 1 | 1 = complementary offset binary coding |
| wck_start_rise | input | 1 | 1 = word start on word-clock rising edge |
| dg_low_slot | input | 5 | Slot where the deglitch strobe falls |
| dg_high_slot | input | 5 | Slot where the deglitch strobe rises |
| smp_valid | input | 1 | New sample pair offered |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| smp_ready | output | 1 | Sample pair taken on this clock edge if valid |
| bck_o | output | 1 | Gated bit clock |
| wck_o | output | 1 | Word clock |
| sdo_left | output | 1 | Left serial data |
| sdo_right | output | 1 | Right serial data |
| dg_o | output | 1 | Deglitch strobe |

## Verification
The bench builds the block with its defaults, `CLK_PER_FS`=512 and `SAMPLE_W`=24. With these values all three oversampling ratios give a slot size of 2, 4 or 8 clocks. Even the 24-bit word at 8x leaves a 16-clock quiet window, so the quiet time, the slot grid and the longest word can all be checked at every rate. Each output period is captured clock by clock and compared with the waveform computed from the requirements. The captures include a mid-period change of every configuration input, equal and zero deglitch slots, and the reserved ratio code.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;

    typedef enum logic [1:0] {
        SEQ_LOW  = 2'd0,
        SEQ_HIGH = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [1:0] osr;
        logic [1:0] wlen;
        logic       cob;
        logic       wck_rise;
        logic [4:0] dg_fall;
        logic [4:0] dg_rise;
    } fmt_cfg_t;

    // log2 of the oversampling ratio; code 11 is treated as 8x
    function automatic int osr_lg(input logic [1:0] sel);
        case (sel)
            2'b01:   return 2;
            2'b10:   return 1;
            default: return 3;
        endcase
    endfunction

    // bits per output word; the 2x ratio always uses 24 bits
    function automatic logic [4:0] word_bits(input logic [1:0] osr, input logic [1:0] len);
        if (osr == 2'b10) return 5'd24;
        case (len)
            2'b00:   return 5'd16;
            2'b01:   return 5'd18;
            2'b10:   return 5'd20;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/dsf_timebase.sv
module dsf_timebase
    import dac_stream_pkg::*;
#(
    parameter int CLK_PER_FS = 512,
    parameter int PH_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  fmt_cfg_t        cfg_in,
    output fmt_cfg_t        cfg_eff,
    output logic            at_start,
    output logic [PH_W-1:0] ph,
    output logic [PH_W-1:0] period_m1,
    output logic            first_half,
    output logic [4:0]      slot,
    output logic            slot_start
);
    localparam int SYS_LG = $clog2(CLK_PER_FS);

    fmt_cfg_t        cfg_q;
    logic [PH_W-1:0] ph_q;
    int              per_lg;
    int              sub_lg;

    assign ph = ph_q;

    always_comb begin
        at_start   = (ph_q == '0);
        cfg_eff    = at_start ? cfg_in : cfg_q;
        per_lg     = SYS_LG - osr_lg(cfg_eff.osr);
        sub_lg     = per_lg - 5;
        period_m1  = PH_W'((32'd1 << per_lg) - 32'd1);
        first_half = (32'(ph_q) < (32'd1 << (per_lg - 1)));
        slot       = 5'(32'(ph_q) >> sub_lg);
        slot_start = ((32'(ph_q) & ((32'd1 << sub_lg) - 32'd1)) == 32'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            cfg_q <= '0;
        end else begin
            ph_q <= (ph_q == period_m1) ? '0 : ph_q + 1'b1;
            if (at_start) cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/dsf_seq.sv
module dsf_seq
    import dac_stream_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph,
    input  logic [PH_W-1:0] period_m1,
    input  logic [4:0]      nbits,
    output logic            bck,
    output logic [4:0]      bit_idx,
    output logic            load_bit
);
    seq_state_t st, st_nx;
    logic [4:0] idx_nx;
    logic       end_of_period;
    logic       last_bit;

    assign end_of_period = (ph == period_m1);
    assign last_bit      = (bit_idx == nbits - 5'd1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_LOW;
            bit_idx <= '0;
        end else begin
            st      <= st_nx;
            bit_idx <= idx_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx  = st;
        idx_nx = bit_idx;
        unique case (st)
            SEQ_LOW: begin
                st_nx = SEQ_HIGH;
            end
            SEQ_HIGH: begin
                if (last_bit) begin
                    idx_nx = '0;
                    st_nx  = end_of_period ? SEQ_LOW : SEQ_HOLD;
                end else begin
                    idx_nx = bit_idx + 5'd1;
                    st_nx  = SEQ_LOW;
                end
            end
            SEQ_HOLD: begin
                if (end_of_period) st_nx = SEQ_LOW;
            end
        endcase
    end

    // outputs
    assign load_bit = (st == SEQ_LOW);

    always_ff @(posedge clk) begin
        if (!rst_n) bck <= 1'b1;
        else        bck <= (st != SEQ_LOW);
    end

endmodule

// File: rtl/dsf_lane.sv
module dsf_lane #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                load_bit,
    input  logic [4:0]          bit_idx,
    input  logic                cob,
    output logic                sdo
);
    logic [SAMPLE_W-1:0] raw_q;
    logic [SAMPLE_W-1:0] raw_cur;
    logic                bit_val;

    always_comb begin
        raw_cur = take ? sample_in : raw_q;
        bit_val = raw_cur[SAMPLE_W - 1 - int'(bit_idx)] ^ (cob && (bit_idx != 5'd0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            sdo   <= 1'b0;
        end else begin
            raw_q <= raw_cur;
            if (load_bit) sdo <= bit_val;
        end
    end

endmodule

// File: rtl/dsf_strobe.sv
module dsf_strobe (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] slot,
    input  logic       slot_start,
    input  logic [4:0] fall_at,
    input  logic [4:0] rise_at,
    output logic       dg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dg <= 1'b1;
        end else if (slot_start) begin
            if (slot == rise_at)      dg <= 1'b1;
            else if (slot == fall_at) dg <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_stream_fmt.sv
module dac_stream_fmt
    import dac_stream_pkg::*;
#(
    parameter int CLK_PER_FS = 512,
    parameter int SAMPLE_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          osr_sel,
    input  logic [1:0]          len_sel,
    input  logic                offset_bin,
    input  logic                wck_start_rise,
    input  logic [4:0]          dg_low_slot,
    input  logic [4:0]          dg_high_slot,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output logic                bck_o,
    output logic                wck_o,
    output logic                sdo_left,
    output logic                sdo_right,
    output logic                dg_o
);
    localparam int PH_W      = $clog2(CLK_PER_FS) - 1;
    localparam int NUM_LANES = 2;

    fmt_cfg_t        cfg_in;
    fmt_cfg_t        cfg_eff;
    logic            at_start;
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] period_m1;
    logic            first_half;
    logic [4:0]      slot;
    logic            slot_start;
    logic [4:0]      nbits;
    logic [4:0]      bit_idx;
    logic            load_bit;
    logic            take;

    logic [SAMPLE_W-1:0] lane_in  [NUM_LANES];
    logic                lane_out [NUM_LANES];

    always_comb begin
        cfg_in.osr      = osr_sel;
        cfg_in.wlen     = len_sel;
        cfg_in.cob      = offset_bin;
        cfg_in.wck_rise = wck_start_rise;
        cfg_in.dg_fall  = dg_low_slot;
        cfg_in.dg_rise  = dg_high_slot;
    end

    assign nbits      = word_bits(cfg_eff.osr, cfg_eff.wlen);
    assign take       = at_start & smp_valid;
    assign smp_ready  = at_start;
    assign lane_in[0] = smp_left;
    assign lane_in[1] = smp_right;
    assign sdo_left   = lane_out[0];
    assign sdo_right  = lane_out[1];

    dsf_timebase #(.CLK_PER_FS(CLK_PER_FS), .PH_W(PH_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_in     (cfg_in),
        .cfg_eff    (cfg_eff),
        .at_start   (at_start),
        .ph         (ph),
        .period_m1  (period_m1),
        .first_half (first_half),
        .slot       (slot),
        .slot_start (slot_start)
    );

    dsf_seq #(.PH_W(PH_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .period_m1 (period_m1),
        .nbits     (nbits),
        .bck       (bck_o),
        .bit_idx   (bit_idx),
        .load_bit  (load_bit)
    );

    for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
        dsf_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (take),
            .sample_in (lane_in[c]),
            .load_bit  (load_bit),
            .bit_idx   (bit_idx),
            .cob       (cfg_eff.cob),
            .sdo       (lane_out[c])
        );
    end

    dsf_strobe u_dg (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .slot_start (slot_start),
        .fall_at    (cfg_eff.dg_fall),
        .rise_at    (cfg_eff.dg_rise),
        .dg         (dg_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wck_o <= ~wck_start_rise;
        else        wck_o <= first_half ? cfg_eff.wck_rise : ~cfg_eff.wck_rise;
    end

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_ready,
    input logic bck_o,
    input logic sdo_left,
    input logic sdo_right
);
    // R8: the take window is a single clock
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R4: the bit clock is parked high when a new word is about to start
    p_bck_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> bck_o);

    // R3: left data moves only with a bit clock fall
    p_left_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_left) |-> $fell(bck_o));

    // R3: right data moves only with a bit clock fall
    p_right_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_right) |-> $fell(bck_o));

endmodule

bind dac_stream_fmt dsf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_ready (smp_ready),
    .bck_o     (bck_o),
    .sdo_left  (sdo_left),
    .sdo_right (sdo_right)
);

// File: tb/dac_stream_fmt_test.sv
module dac_stream_fmt_test;
    localparam int CPF = 512;
    localparam int SW  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    osr_sel = 2'b00;
    logic [1:0]    len_sel = 2'b00;
    logic          offset_bin = 1'b0;
    logic          wck_start_rise = 1'b0;
    logic [4:0]    dg_low_slot = 5'd15;
    logic [4:0]    dg_high_slot = 5'd31;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_left = '0;
    logic [SW-1:0] smp_right = '0;
    logic          smp_ready, bck_o, wck_o, sdo_left, sdo_right, dg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [SW-1:0] held_l = '0;
    logic [SW-1:0] held_r = '0;
    logic last_pol = 1'b0;

    always #4 clk = ~clk;

    dac_stream_fmt #(.CLK_PER_FS(CPF), .SAMPLE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .osr_sel(osr_sel), .len_sel(len_sel),
        .offset_bin(offset_bin), .wck_start_rise(wck_start_rise),
        .dg_low_slot(dg_low_slot), .dg_high_slot(dg_high_slot),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .smp_ready(smp_ready), .bck_o(bck_o), .wck_o(wck_o),
        .sdo_left(sdo_left), .sdo_right(sdo_right), .dg_o(dg_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one full output period, compared cycle by cycle with the computed waveform
    task automatic run_period(input logic [1:0] osr, input logic [1:0] len, input logic cob,
                              input logic pol, input logic [4:0] fs, input logic [4:0] rs,
                              input logic valid, input logic [SW-1:0] l, input logic [SW-1:0] r,
                              input bit disturb, input string tag);
        int lg, per, nb, ss, rises, bad_d, bad_b, bad_w, bad_g, readies, bad_rdy_pos;
        logic [SW-1:0] wl, wr;
        logic pb, pd, pw, w0, same_pol;
        while (!smp_ready) @(negedge clk);
        osr_sel = osr; len_sel = len; offset_bin = cob; wck_start_rise = pol;
        dg_low_slot = fs; dg_high_slot = rs; smp_valid = valid; smp_left = l; smp_right = r;
        pb = bck_o; pd = dg_o; pw = wck_o; same_pol = (pol == last_pol);
        case (osr)
            2'b01:   lg = 2;
            2'b10:   lg = 1;
            default: lg = 3;
        endcase
        per = CPF >> lg;
        ss  = per / 32;
        if (osr == 2'b10) nb = 24;
        else case (len)
            2'b00: nb = 16;
            2'b01: nb = 18;
            2'b10: nb = 20;
            default: nb = 24;
        endcase
        wl = valid ? l : held_l;
        wr = valid ? r : held_r;
        held_l = wl; held_r = wr;
        rises = 0; bad_d = 0; bad_b = 0; bad_w = 0; bad_g = 0; readies = 0; bad_rdy_pos = 0;
        w0 = 1'b0;
        for (int i = 0; i < per; i++) begin
            int bi;
            logic eb, ew, el, er;
            @(negedge clk);
            if (i == 0) begin smp_valid = 1'b0; w0 = wck_o; end
            if (disturb && i == 2) begin
                osr_sel = osr ^ 2'b01; len_sel = ~len; offset_bin = ~cob;
                wck_start_rise = ~pol; dg_low_slot = rs; dg_high_slot = fs;
            end
            bi = (i / 2 < nb) ? i / 2 : nb - 1;
            eb = (i < 2 * nb) ? logic'(i % 2) : 1'b1;
            ew = (i < per / 2) ? pol : ~pol;
            el = wl[SW-1-bi] ^ (cob && bi != 0);
            er = wr[SW-1-bi] ^ (cob && bi != 0);
            if (i % ss == 0) begin
                if (i / ss == int'(rs))      pd = 1'b1;
                else if (i / ss == int'(fs)) pd = 1'b0;
            end
            if (bck_o && !pb) rises++;
            pb = bck_o;
            if (bck_o !== eb) bad_b++;
            if (wck_o !== ew) bad_w++;
            if (sdo_left !== el || sdo_right !== er) bad_d++;
            if (dg_o !== pd) bad_g++;
            if (smp_ready) begin readies++; if (i != per - 1) bad_rdy_pos++; end
        end
        check("R1", "ready pulses per period", readies, 1);
        check("R1", "ready pulses at wrong cycle", bad_rdy_pos, 0);
        check("R2", "bit clock rising edges", rises, nb);
        check(tag, "serial data mismatched cycles", bad_d, 0);
        check("R4", "bit clock mismatched cycles", bad_b, 0);
        check("R5", "word clock mismatched cycles", bad_w, 0);
        if (same_pol) check("R5", "word clock start edge moved", (w0 != pw), 1);
        check("R7", "deglitch mismatched cycles", bad_g, 0);
        last_pol = pol;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9", "reset bit clock", bck_o, 1);
        check("R9", "reset deglitch", dg_o, 1);
        check("R9", "reset ready", smp_ready, 1);
        check("R9", "reset data", {sdo_left, sdo_right}, 0);
        check("R9", "reset word clock", wck_o, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();       // R3 default two's complement at 8x, 16 bits
        run_period(2'b00, 2'b00, 1'b0, 1'b0, 5'd15, 5'd31, 1'b1, 24'hA5C3_96, 24'h3C_0F_E1, 1'b0, "R3");
        run_period(2'b00, 2'b11, 1'b0, 1'b0, 5'd15, 5'd31, 1'b1, 24'h81_2345, 24'h7E_DCBA, 1'b0, "R3");
    endtask

    task automatic t_offset();      // R6
        run_period(2'b00, 2'b11, 1'b1, 1'b0, 5'd15, 5'd31, 1'b1, 24'h80_0001, 24'h12_F00F, 1'b0, "R6");
        run_period(2'b01, 2'b01, 1'b1, 1'b0, 5'd3, 5'd20, 1'b1, 24'h00_0000, 24'hFF_FFFF, 1'b0, "R6");
    endtask

    task automatic t_lengths();     // R2 at 4x and the forced 24-bit 2x case
        run_period(2'b01, 2'b10, 1'b0, 1'b1, 5'd7, 5'd28, 1'b1, 24'h5A_5A5A, 24'hC3_3C99, 1'b0, "R3");
        run_period(2'b10, 2'b00, 1'b0, 1'b1, 5'd0, 5'd16, 1'b1, 24'hDE_AD01, 24'h0B_EEF5, 1'b0, "R2");
    endtask

    task automatic t_repeat();      // R8
        run_period(2'b00, 2'b10, 1'b0, 1'b0, 5'd15, 5'd31, 1'b1, 24'h9F_3310, 24'h61_AA55, 1'b0, "R8");
        run_period(2'b00, 2'b10, 1'b0, 1'b0, 5'd15, 5'd31, 1'b0, 24'h00_FFFF, 24'hFF_0000, 1'b0, "R8");
    endtask

    task automatic t_disturb();     // R10
        run_period(2'b00, 2'b00, 1'b0, 1'b0, 5'd10, 5'd25, 1'b1, 24'h47_1E2D, 24'hB8_E1D2, 1'b1, "R10");
        run_period(2'b01, 2'b11, 1'b1, 1'b0, 5'd10, 5'd25, 1'b1, 24'h13_5790, 24'hEC_A86F, 1'b1, "R10");
    endtask

    task automatic t_slots();       // R7 equal slots (high wins) and the reserved ratio code (R1)
        run_period(2'b00, 2'b00, 1'b0, 1'b0, 5'd9, 5'd9, 1'b1, 24'h66_6666, 24'h99_9999, 1'b0, "R3");
        run_period(2'b11, 2'b00, 1'b0, 1'b0, 5'd0, 5'd31, 1'b1, 24'h70_0007, 24'h0F_F0F0, 1'b0, "R1");
        run_period(2'b10, 2'b11, 1'b0, 1'b0, 5'd31, 5'd1, 1'b1, 24'h2B_4C6D, 24'hD4_B392, 1'b0, "R3");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_offset();
        t_lengths();
        t_repeat();
        t_disturb();
        t_slots();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule